// File: doc/BRIEF.md
# Converter Control and Status Register

This block is the 8-bit control and status register of one analog-to-digital converter module. It sits on a simple CPU register bus that has a one-cycle write strobe, a one-cycle read strobe, an 8-bit write data bus and combinational read data. The register holds a conversion-end flag, an interrupt enable and a mode select that chooses single or scan mode. The block drives the end-of-conversion interrupt request and exports the mode bit to the channel sequencer.

The flag is set by pulses from the conversion sequencer. In single mode a "conversion done" pulse sets it. In scan mode only an "all selected channels done" pulse sets it. Software clears the flag with a guarded sequence: a CPU read must first return the flag as 1, and only after that is a write of 0 to the flag honoured. A DMA read of the result register also clears the flag, unless a hold qualifier input is high. The mode bit is locked while the converter's start input is 1.

Top module: `adc_csr_top`

## Requirements
- R1: After reset the register reads 8'h08, `eoc_irq` is 0 and `scan_mode` is 0.
- R2: In single mode (bit 4 = 0) a `seq_conv_done` pulse sets the flag (bit 7) on the next clock. A `seq_scan_done` pulse has no effect on the flag.
- R3: In scan mode (bit 4 = 1) a `seq_scan_done` pulse sets the flag on the next clock. A `seq_conv_done` pulse has no effect on the flag.
- R4: A CPU write with bit 7 = 1 never sets the flag.
- R5: A CPU write with bit 7 = 0 clears the flag only when a CPU read has returned the flag as 1 since the flag was last set. Otherwise the flag keeps its value.
- R6: A `dma_res_rd` pulse clears the flag when `dma_hold_flag` is 0. When `dma_hold_flag` is 1 the pulse has no effect on the flag.
- R7: If a set pulse and a clear request arrive in the same cycle, the flag is 1 after that clock.
- R8: Bit 6 is the interrupt enable. It resets to 0 and takes the written value on every CPU write. `eoc_irq` is 1 exactly when bit 6 and bit 7 are both 1.
- R9: Bit 4 takes the written value on a CPU write only while `conv_start` is 0. While `conv_start` is 1 it keeps its previous value. `scan_mode` always equals bit 4.
- R10: Bits 5, 2, 1 and 0 always read 0 and bit 3 always reads 1, whatever value is written.
- R11: A new set pulse cancels an earlier read of the flag as 1. A following write of 0 is ignored until the flag has been read as 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_stb | input | 1 | One-cycle CPU write strobe |
| cpu_rd_stb | input | 1 | One-cycle CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Combinational register read value |
| seq_conv_done | input | 1 | Sequencer pulse: a single conversion finished |
| seq_scan_done | input | 1 | Sequencer pulse: all selected channels finished |
| dma_res_rd | input | 1 | Pulse: DMA read of the result register |
| dma_hold_flag | input | 1 | High: the DMA read must not clear the flag |
| conv_start | input | 1 | Converter start bit; while high the mode is locked |
| eoc_irq | output | 1 | End-of-conversion interrupt request |
| scan_mode | output | 1 | Mode bit: 1 for scan, 0 for single |

## Verification
The embedded assertions check four things on every cycle. A set pulse always leaves the flag at 1. The flag never rises without a set pulse. It never falls without an earlier qualifying read or an unheld DMA read. The mode bit stays put while the start input is high. Only the bench scenarios can show the following. The fixed bit values hold across all 256 write values in both start states. The guard is rearmed by a new end event. The mode choice decides which sequencer pulse counts. A long pseudo-random stream agrees with an independently written flag model.

// File: rtl/adc_csr_pkg.sv
package adc_csr_pkg;
    localparam int REG_W    = 8;
    localparam int FLAG_POS = 7;
    localparam int IE_POS   = 6;
    localparam int MODE_POS = 4;
    // value of the bits that never change (bit 3 high, others low)
    localparam logic [REG_W-1:0] FIXED_VAL  = 8'h08;
    localparam logic [REG_W-1:0] LIVE_MASK  = (REG_W'(1) << FLAG_POS)
                                            | (REG_W'(1) << IE_POS)
                                            | (REG_W'(1) << MODE_POS);

    typedef struct packed {
        logic flag;
        logic seen;   // flag was read as 1 since the last set
    } flag_st_t;

    typedef struct packed {
        logic ie;
        logic mode;
    } ctrl_st_t;
endpackage

// File: rtl/adc_csr_flag.sv
module adc_csr_flag
    import adc_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_scan,
    input  logic conv_done,
    input  logic scan_done,
    input  logic cpu_rd,
    input  logic cpu_wr,
    input  logic wr_flag_bit,
    input  logic dma_rd,
    input  logic dma_hold,
    output logic flag_q
);
    flag_st_t st_d, st_q;
    logic set_ev, clr_req;

    always_comb begin
        set_ev  = mode_scan ? scan_done : conv_done;
        clr_req = (cpu_wr && !wr_flag_bit && st_q.seen) || (dma_rd && !dma_hold);
        st_d    = st_q;
        if (set_ev) begin
            st_d.flag = 1'b1;
            st_d.seen = 1'b0;
        end else if (clr_req) begin
            st_d.flag = 1'b0;
            st_d.seen = 1'b0;
        end else if (cpu_rd && st_q.flag) begin
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q = st_q.flag;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> st_q.flag);

    assert_no_write_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(set_ev));

    assert_guarded_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> ($past(st_q.seen) || $past(dma_rd && !dma_hold)));

    assert_dma_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd && !dma_hold && !set_ev) |=> !st_q.flag);
endmodule

// File: rtl/adc_csr_ctrl.sv
module adc_csr_ctrl
    import adc_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_wr,
    input  logic wr_ie,
    input  logic wr_mode,
    input  logic start_in,
    output logic ie_q,
    output logic mode_q
);
    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cpu_wr) begin
            st_d.ie = wr_ie;
            if (!start_in) st_d.mode = wr_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ie_q   = st_q.ie;
    assign mode_q = st_q.mode;

    assert_mode_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_in |=> $stable(st_q.mode));
endmodule

// File: rtl/adc_csr_top.sv
module adc_csr_top
    import adc_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr_stb,
    input  logic             cpu_rd_stb,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             seq_conv_done,
    input  logic             seq_scan_done,
    input  logic             dma_res_rd,
    input  logic             dma_hold_flag,
    input  logic             conv_start,
    output logic             eoc_irq,
    output logic             scan_mode
);
    logic flag_q, ie_q, mode_q;

    adc_csr_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_wr   (cpu_wr_stb),
        .wr_ie    (cpu_wdata[IE_POS]),
        .wr_mode  (cpu_wdata[MODE_POS]),
        .start_in (conv_start),
        .ie_q     (ie_q),
        .mode_q   (mode_q)
    );

    adc_csr_flag flag_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_scan   (mode_q),
        .conv_done   (seq_conv_done),
        .scan_done   (seq_scan_done),
        .cpu_rd      (cpu_rd_stb),
        .cpu_wr      (cpu_wr_stb),
        .wr_flag_bit (cpu_wdata[FLAG_POS]),
        .dma_rd      (dma_res_rd),
        .dma_hold    (dma_hold_flag),
        .flag_q      (flag_q)
    );

    logic [REG_W-1:0] live_bits;

    always_comb begin
        live_bits           = '0;
        live_bits[FLAG_POS] = flag_q;
        live_bits[IE_POS]   = ie_q;
        live_bits[MODE_POS] = mode_q;
    end

    // fixed bits come from the constant, live bits from state
    for (genvar b = 0; b < REG_W; b++) begin : g_rd
        if (LIVE_MASK[b]) begin : g_live
            assign cpu_rdata[b] = live_bits[b];
        end else begin : g_fixed
            assign cpu_rdata[b] = FIXED_VAL[b];
        end
    end

    assign eoc_irq   = ie_q & flag_q;
    assign scan_mode = mode_q;

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_irq) |-> ($past(seq_conv_done || seq_scan_done) || $past(cpu_wr_stb)));
endmodule

// File: tb/adc_csr_top_tb_top.sv
module adc_csr_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cdone = 1'b0, sdone = 1'b0, dma = 1'b0, hold = 1'b0, start = 1'b0;
    logic       irq, smode;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // independent reference state
    logic m_flag = 0, m_ie = 0, m_mode = 0, m_seen = 0;

    always #2.5 clk = ~clk;

    adc_csr_top dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr_stb(wr), .cpu_rd_stb(rd),
        .cpu_wdata(wdata), .cpu_rdata(rdata), .seq_conv_done(cdone),
        .seq_scan_done(sdone), .dma_res_rd(dma), .dma_hold_flag(hold),
        .conv_start(start), .eoc_irq(irq), .scan_mode(smode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string flag_req);
        chk(flag_req, 8'(rdata[7]), 8'(m_flag));
        chk("R8 ie",     8'(rdata[6]), 8'(m_ie));
        chk("R9 mode",   8'(rdata[4]), 8'(m_mode));
        chk("R10 fixed", rdata & 8'h2F, 8'h08);
        chk("R8 irq",    8'(irq), 8'(m_ie & m_flag));
        chk("R9 out",    8'(smode), 8'(m_mode));
    endtask

    // apply one cycle of stimulus at a falling edge, advance, check
    task automatic step(input string req, input bit w, input bit r, input logic [7:0] d,
                        input bit cd, input bit sd, input bit dm, input bit hd, input bit st);
        logic set_e, clr_e, nf;
        wr = w; rd = r; wdata = d; cdone = cd; sdone = sd; dma = dm; hold = hd; start = st;
        set_e = m_mode ? sd : cd;
        clr_e = (w && !d[7] && m_seen) || (dm && !hd);
        nf    = set_e | (m_flag & ~clr_e);
        if (set_e || !nf)       m_seen = 0;
        else if (r && m_flag)   m_seen = 1;
        m_flag = nf;
        if (w) begin
            m_ie = d[6];
            if (!st) m_mode = d[4];
        end
        @(negedge clk);
        wr = 0; rd = 0; cdone = 0; sdone = 0; dma = 0; hold = 0;
        check_all(req);
    endtask

    task automatic idle(input string req);
        step(req, 0, 0, 8'h00, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset value
        chk("R1 rdata", rdata, 8'h08);
        chk("R1 irq", 8'(irq), 8'h00);
        chk("R1 scan", 8'(smode), 8'h00);

        // R10/R9/R8/R4: sweep all write values with start low and high
        for (int s = 0; s < 2; s++)
            for (int v = 0; v < 256; v++)
                step("R4 write1", 1, 0, 8'(v), 0, 0, 0, 0, s[0]);

        // R2 single mode
        step("R9 setmode", 1, 0, 8'h00, 0, 0, 0, 0, 0);
        step("R2 scan ignored", 0, 0, 8'h00, 0, 1, 0, 0, 0);
        step("R2 set", 0, 0, 8'h00, 1, 0, 0, 0, 0);
        // R5 write 0 without read ignored
        step("R5 unguarded", 1, 0, 8'h40, 0, 0, 0, 0, 0);
        step("R5 read", 0, 1, 8'h00, 0, 0, 0, 0, 0);
        step("R5 guarded", 1, 0, 8'h40, 0, 0, 0, 0, 0);
        // R11 rearm by new set
        step("R2 set2", 0, 0, 8'h00, 1, 0, 0, 0, 0);
        step("R11 read", 0, 1, 8'h40, 0, 0, 0, 0, 0);
        step("R11 newset", 0, 0, 8'h00, 1, 0, 0, 0, 0);
        step("R11 stale", 1, 0, 8'h40, 0, 0, 0, 0, 0);
        chk("R11 flag kept", 8'(rdata[7]), 8'h01);
        // R6 DMA
        step("R6 held", 0, 0, 8'h00, 0, 0, 1, 1, 0);
        chk("R6 held flag", 8'(rdata[7]), 8'h01);
        step("R6 clear", 0, 0, 8'h00, 0, 0, 1, 0, 0);
        chk("R6 cleared", 8'(rdata[7]), 8'h00);
        // R7 set and DMA clear together
        step("R7 collide", 0, 0, 8'h00, 1, 0, 1, 0, 0);
        chk("R7 flag", 8'(rdata[7]), 8'h01);
        // R3 scan mode
        step("R6 clr", 0, 0, 8'h00, 0, 0, 1, 0, 0);
        step("R9 scan", 1, 0, 8'h10, 0, 0, 0, 0, 0);
        step("R3 single ignored", 0, 0, 8'h00, 1, 0, 0, 0, 0);
        chk("R3 no set", 8'(rdata[7]), 8'h00);
        step("R3 set", 0, 0, 8'h00, 0, 1, 0, 0, 0);
        chk("R3 flag", 8'(rdata[7]), 8'h01);
        // R9 locked mode
        step("R9 locked", 1, 0, 8'h00, 0, 0, 0, 0, 1);
        chk("R9 still scan", 8'(smode), 8'h01);

        // pseudo-random stream against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R5 stream", lfsr[0] & lfsr[5], lfsr[1], lfsr[15:8],
                 lfsr[2] & lfsr[7], lfsr[3] & lfsr[6], lfsr[4] & lfsr[1] & lfsr[9],
                 lfsr[11], lfsr[12] & lfsr[13]);
        end
        idle("R8 final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule